// File: doc/BRIEF.md
# Grouped Prescaler Tick Generator

This block turns one base clock into five per-channel tick enables for a bank of timer counters. Two 8-bit prescalers divide the base clock. The first drives channels 0 and 1, and the second drives channels 2, 3 and 4. Each channel then picks its own tick source through a 4-bit select code. The code can choose the group's prescaled tick, further divided by 1, 2, 4, 8 or 16. It can also choose the group's external clock input, or it can turn the channel off.

Every output is a single-cycle enable in the base clock domain, suitable as a count strobe for a down-counter. The external clock inputs are asynchronous. They are synchronized and edge-detected, so a slow external clock produces one tick per rising edge. Both configuration words are captured into registers inside the block, and reset clears them. Whenever a prescaler value or a select code changes, the affected counter restarts, so the first tick after a change lands at a known cycle.

Top module: `grouped_tick_gen`

## Requirements
- R1: While rst_ni is low, tick_o is all zeros. After reset is released with both configuration words at zero, every channel ticks on every cycle, starting at the first rising clock edge after release.
- R2: A prescaler with field value p yields a tick period of p+1 base cycles, for a channel whose select code is 0.
- R3: cfg_pre_i[7:0] sets prescaler 0, which serves channels 0 and 1. cfg_pre_i[15:8] sets prescaler 1, which serves channels 2, 3 and 4. Changing one prescaler has no effect on the other group's tick period.
- R4: The select code of channel c is cfg_mux_i[4c+3:4c]. Codes 0 to 4 divide the group's prescaled tick by 2^code, giving a period of (p+1)·2^code cycles.
- R5: Codes 5, 6 and 7 select the group's external clock. ext_clk_i[0] serves channels 0 and 1, and ext_clk_i[1] serves channels 2 to 4. The channel gives exactly one tick per rising edge of that input, and it ignores the other group's external clock.
- R6: An external clock that stays high for many cycles produces only one single-cycle tick. Two ticks never occur on consecutive cycles for an external source.
- R7: Codes 8 to 15 produce no ticks on that channel.
- R8: Suppose a prescaler value changes to p while the channel code is 0, with the new value applied before rising edge 1. The first tick appears on tick_o after rising edge 3+p. No tick appears after edge 2.
- R9: Suppose a channel's code changes to m in the range 0 to 4, with the prescaler at 0 and the new code applied before rising edge 1. The first tick appears after rising edge 2+2^m.
- R10: Every tick lasts exactly one cycle whenever the effective period is longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_pre_i | input | 16 | Prescaler values, group 0 in bits 7:0 and group 1 in bits 15:8 |
| cfg_mux_i | input | 20 | Per-channel 4-bit select codes, channel c at bits 4c+3:4c |
| ext_clk_i | input | 2 | Asynchronous external clocks, one per group |
| tick_o | output | 5 | Per-channel single-cycle tick enables |

## Verification
The bench measures periods across several prescaler and divider combinations. A design that wires a channel to the wrong group's prescaler shows a period that tracks the wrong field. The restart tests count edges from a configuration change to the first tick. A design that keeps its stale count produces a first tick that arrives early or late, and one that fails to suppress the change cycle produces a spurious tick after edge 2. The external tests hold the external clock high for long stretches and toggle only one group's input. A level-sensitive design would then stream ticks, and a design with crossed group wiring would tick on the wrong channels.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;
  parameter int unsigned NUM_CH   = 5;
  parameter int unsigned PRE_W    = 8;
  parameter int unsigned MUX_W    = 4;
  parameter int unsigned MAX_LOG2 = 4;
  parameter int unsigned EXT_LO   = 5;
  parameter int unsigned EXT_HI   = 7;
  parameter int unsigned GRP0_CH  = 2;

  typedef enum logic [1:0] {SRC_DIV, SRC_EXT, SRC_OFF} src_e;

  function automatic src_e decode_src(input logic [MUX_W-1:0] code);
    if (int'(code) <= int'(MAX_LOG2)) return SRC_DIV;
    if (int'(code) >= int'(EXT_LO) && int'(code) <= int'(EXT_HI)) return SRC_EXT;
    return SRC_OFF;
  endfunction
endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_val_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, last_q;
  logic         changed;

  assign changed = (div_val_i != last_q);
  assign tick_o  = !changed && (cnt_q == div_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      last_q <= div_val_i;
      if (changed || cnt_q == div_val_i) cnt_q <= '0;
      else                               cnt_q <= cnt_q + W'(1);
    end
  end

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !changed |-> (cnt_q <= div_val_i));
  a_r2_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_val_i != '0) |=> !tick_o);
endmodule

// File: rtl/tg_ext_edge.sv
module tg_ext_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic tick_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ext_i};
  end

  assign tick_o = sync_q[1] & ~sync_q[2];

  a_r6_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tg_chan_sel.sv
module tg_chan_sel
  import tick_gen_pkg::*;
#(
  parameter int unsigned CODE_W = MUX_W,
  parameter int unsigned LOG_W  = MAX_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pre_tick_i,
  input  logic              ext_tick_i,
  output logic              tick_o
);
  logic [LOG_W-1:0]  div_q, mask;
  logic [CODE_W-1:0] last_q;
  logic              changed, div_hit;
  src_e              src;

  assign src     = decode_src(code_i);
  assign changed = (code_i != last_q);

  always_comb begin
    mask = '0;
    for (int i = 0; i < int'(LOG_W); i++)
      if (i < int'(code_i)) mask[i] = 1'b1;
  end

  assign div_hit = pre_tick_i && ((div_q & mask) == mask);

  always_comb begin
    tick_o = 1'b0;
    if (!changed) begin
      unique case (src)
        SRC_DIV: tick_o = div_hit;
        SRC_EXT: tick_o = ext_tick_i;
        default: tick_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      last_q <= '0;
    end else begin
      last_q <= code_i;
      if (changed)                         div_q <= '0;
      else if (src == SRC_DIV && pre_tick_i) div_q <= div_q + LOG_W'(1);
    end
  end

  a_r10_div_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && src == SRC_DIV && code_i != '0) |=> !tick_o);
  a_r5_ext_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && src == SRC_EXT) |-> ext_tick_i);
endmodule

// File: rtl/grouped_tick_gen.sv
module grouped_tick_gen
  import tick_gen_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned P_W    = PRE_W,
  parameter int unsigned C_W    = MUX_W,
  parameter int unsigned G0_CH  = GRP0_CH,
  localparam int unsigned NGRP  = 2,
  localparam int unsigned PRE_TW = NGRP * P_W,
  localparam int unsigned MUX_TW = N_CH * C_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRE_TW-1:0] cfg_pre_i,
  input  logic [MUX_TW-1:0] cfg_mux_i,
  input  logic [NGRP-1:0]   ext_clk_i,
  output logic [N_CH-1:0]   tick_o
);
  logic [PRE_TW-1:0] pre_q;
  logic [MUX_TW-1:0] mux_q;
  logic [NGRP-1:0]   pre_tick, ext_tick;
  logic [N_CH-1:0]   tick_d, tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      mux_q  <= '0;
      tick_q <= '0;
    end else begin
      pre_q  <= cfg_pre_i;
      mux_q  <= cfg_mux_i;
      tick_q <= tick_d;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    tg_prescaler #(.W(P_W)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .div_val_i (pre_q[g*P_W +: P_W]),
      .tick_o    (pre_tick[g])
    );
    tg_ext_edge u_ext (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ext_i  (ext_clk_i[g]),
      .tick_o (ext_tick[g])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned GRP = (c < G0_CH) ? 0 : 1;
    tg_chan_sel #(.CODE_W(C_W), .LOG_W(MAX_LOG2)) u_sel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .code_i     (mux_q[c*C_W +: C_W]),
      .pre_tick_i (pre_tick[GRP]),
      .ext_tick_i (ext_tick[GRP]),
      .tick_o     (tick_d[c])
    );

    a_r7_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (decode_src(mux_q[c*C_W +: C_W]) == SRC_OFF) |=> !tick_q[c]);
  end

  assign tick_o = tick_q;

  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (tick_q == '0);
  end
endmodule

// File: tb/grouped_tick_gen_tb_top.sv
module grouped_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_pre = '0;
  logic [19:0] cfg_mux = '0;
  logic [1:0]  ext_clk = '0;
  logic [4:0]  tick;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cnt [5];

  always #4 clk = ~clk;

  grouped_tick_gen dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cfg_pre_i (cfg_pre),
    .cfg_mux_i (cfg_mux),
    .ext_clk_i (ext_clk),
    .tick_o    (tick)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_code(input int ch, input int code);
    cfg_mux[ch*4 +: 4] = 4'(code);
  endtask

  task automatic measure(input string req, input int ch, input int exp);
    int n = 0;
    int w = 0;
    while (!tick[ch] && w < 5000) begin @(negedge clk); w++; end
    @(negedge clk); n = 1;
    while (!tick[ch] && n < 5000) begin @(negedge clk); n++; end
    check(req, $sformatf("period ch%0d", ch), n, exp);
  endtask

  task automatic sample_cycle();
    @(negedge clk);
    for (int c = 0; c < 5; c++) cnt[c] += int'(tick[c]);
  endtask

  task automatic clear_cnt();
    for (int c = 0; c < 5; c++) cnt[c] = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "tick in reset", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "tick after release", int'(tick), 31);
    @(negedge clk);
    check("R1", "tick second cycle", int'(tick), 31);
  endtask

  task automatic t_groups();
    @(negedge clk);
    cfg_pre = {8'd4, 8'd2};
    cfg_mux = '0;
    repeat (10) @(negedge clk);
    measure("R2", 0, 3);
    measure("R3", 1, 3);
    measure("R3", 2, 5);
    measure("R3", 4, 5);
    @(negedge clk);
    cfg_pre[15:8] = 8'd9;
    repeat (5) @(negedge clk);
    measure("R3", 0, 3);
    measure("R2", 3, 10);
  endtask

  task automatic t_divs();
    @(negedge clk);
    cfg_pre = {8'd1, 8'd2};
    set_code(1, 3); set_code(3, 2); set_code(4, 4); set_code(0, 1);
    repeat (10) @(negedge clk);
    measure("R4", 1, 24);
    measure("R4", 3, 8);
    measure("R4", 4, 32);
    measure("R4", 0, 6);
    measure("R10", 2, 2);
  endtask

  task automatic t_restart_pre();
    int n = 0;
    @(negedge clk);
    cfg_pre = '0; cfg_mux = '0;
    repeat (6) @(negedge clk);
    cfg_pre[7:0] = 8'd6;
    @(negedge clk); n = 1;
    @(negedge clk); n = 2;
    check("R8", "no tick at edge 2", int'(tick[0]), 0);
    while (!tick[0] && n < 500) begin @(negedge clk); n++; end
    check("R8", "first tick edge", n, 9);
  endtask

  task automatic t_restart_mux();
    int n = 0;
    @(negedge clk);
    cfg_pre = '0; cfg_mux = '0;
    repeat (6) @(negedge clk);
    set_code(2, 3);
    @(negedge clk); n = 1;
    @(negedge clk); n = 2;
    check("R9", "no tick at edge 2", int'(tick[2]), 0);
    while (!tick[2] && n < 500) begin @(negedge clk); n++; end
    check("R9", "first tick edge", n, 10);
  endtask

  task automatic t_ext();
    @(negedge clk);
    cfg_pre = '0;
    set_code(0, 6); set_code(1, 5); set_code(2, 5); set_code(3, 7); set_code(4, 9);
    repeat (8) @(negedge clk);
    clear_cnt();
    for (int p = 0; p < 5; p++) begin
      ext_clk[1] = 1'b1;
      repeat (4) sample_cycle();
      ext_clk[1] = 1'b0;
      repeat (4) sample_cycle();
    end
    repeat (8) sample_cycle();
    check("R5", "ext1 ticks ch2", cnt[2], 5);
    check("R5", "ext1 ticks ch3", cnt[3], 5);
    check("R5", "ext1 ignored by ch0", cnt[0], 0);
    check("R7", "code 9 silent ch4", cnt[4], 0);
    clear_cnt();
    for (int p = 0; p < 3; p++) begin
      ext_clk[0] = 1'b1;
      repeat (20) sample_cycle();
      ext_clk[0] = 1'b0;
      repeat (3) sample_cycle();
    end
    repeat (8) sample_cycle();
    check("R6", "long high ext0 ch0", cnt[0], 3);
    check("R6", "long high ext0 ch1", cnt[1], 3);
    check("R5", "ext0 ignored by ch2", cnt[2], 0);
  endtask

  task automatic t_off();
    @(negedge clk);
    cfg_pre = '0; cfg_mux = '0;
    set_code(4, 8); set_code(0, 15); set_code(2, 12);
    repeat (4) @(negedge clk);
    clear_cnt();
    ext_clk = 2'b11;
    repeat (20) sample_cycle();
    ext_clk = 2'b00;
    repeat (30) sample_cycle();
    check("R7", "code 8 ch4", cnt[4], 0);
    check("R7", "code 15 ch0", cnt[0], 0);
    check("R7", "code 12 ch2", cnt[2], 0);
    check("R1", "code 0 ch1 every cycle", cnt[1], 50);
  endtask

  initial begin
    t_reset();
    t_groups();
    t_divs();
    t_restart_pre();
    t_restart_mux();
    t_ext();
    t_off();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule